// File: doc/BRIEF.md
# Flash Controller Configuration and Interrupt Register Block

This block is the register front end of a NAND flash controller. A simple single-cycle register bus reaches eight word registers. Three of them drive the controller's configuration pins: the interface configuration, the bus timing and the chip-enable mode. The interface configuration and timing registers are guarded by a lock. Software must first write a 16-bit key to the key register. That opens the lock for exactly one write to a guarded register, and the lock then closes again by itself.

The block also gathers status from the controller datapath. Single-cycle event pulses are held in a sticky pending register. Reading that register returns its contents and clears it in the same access. A mask register selects which pending bits drive the level interrupt output.

A live status register shows the datapath's present ready and error state, with no memory. A combined ready output is high only when both the flash device and the controller report ready. Writing the reset command code to the command register clears the pending events, closes the lock and gives a one-cycle soft reset pulse to the rest of the controller.

Top module: `flashctl_regs`

## Requirements
- R1: After reset every register reads as zero, the lock is closed, `irq` is low and every configuration output is zero.
- R2: A write of 0xA25E in bits 15:0 to the key register (address 5) opens the lock. Reading address 5 returns the lock state in bit 0 (1 = open). The first later write to the configuration register (address 1) or the timing register (address 2) takes effect, and the lock is closed again from the next cycle.
- R3: A write to address 1 or 2 while the lock is closed is ignored. The register keeps its contents.
- R4: Writes to addresses other than 1, 2 and 5 do not close an open lock. A key register write with any value other than 0xA25E closes it.
- R5: The configuration register stores bits 3:0 (bit 3 write protect, bit 2 large-block device, bit 1 five-byte addressing, bit 0 16-bit bus). It reads back at address 1 and drives `if_cfg`. Higher written bits read as zero.
- R6: The timing register stores bits 25:0 with these fields: bits 25:24 chip-enable delay, 23:19 busy delay, 18:16 turnaround, 15:12 read high, 11:8 read low, 7:4 write high, 3:0 write low. It reads back at address 2 and drives `if_timing`.
- R7: A pulse on `ev_pulse` bit n sets pending bit n, readable at address 4. The bit order is 5 flash ready, 4 controller ready, 3 decode failure, 2 decode error, 1 ECC ready, 0 write-protect fault.
- R8: A read of address 4 returns the pending bits and clears them. An event that arrives in the same cycle as that read remains pending afterwards.
- R9: The mask register (address 3, bits 5:0, same layout as the pending register) gates the interrupt. `irq` is high exactly when some pending bit and its mask bit are both set.
- R10: Address 6 reads the live status: bit 0 flash ready, bit 1 controller ready, bit 2 ECC ready, bit 3 errors seen, bits 5:4 corrected-symbol count minus one, bit 6 uncorrectable. `dev_ready` is high only when bits 0 and 1 are both set.
- R11: A write of 0xFF in bits 7:0 to the command register (address 0) clears the pending bits and closes the lock, and `soft_rst` is high for the following cycle. Any other command value has no effect.
- R12: Bit 0 of the chip-enable mode register (address 7) is writable without the key and drives `ce_normal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the access cycle |
| ev_pulse | input | N_EV | Single-cycle status events from the datapath |
| st_nand_rdy | input | 1 | Flash device ready level |
| st_ctl_rdy | input | 1 | Controller ready level |
| st_ecc_rdy | input | 1 | ECC result ready level |
| st_err_seen | input | 1 | Errors detected in the last decode |
| st_fix_cnt | input | 2 | Corrected symbols minus one |
| st_uncorr | input | 1 | Last decode was uncorrectable |
| irq | output | 1 | Level interrupt |
| if_cfg | output | CFG_W | Interface configuration bits |
| if_timing | output | TIM_W | Timing fields |
| ce_normal | output | 1 | Controller-driven chip enable selected |
| dev_ready | output | 1 | Flash and controller both ready |
| soft_rst | output | 1 | One-cycle soft reset pulse |

## Verification
On every cycle, the assertions check the lock sequencing and the pending register. They check that a guarded write always closes the lock, that the correct key always opens it, and that unrelated cycles leave it unchanged. They check that a write while locked leaves the register untouched, that an event is never lost, and that a clearing read with no event leaves the pending register empty. Other behaviour can only be shown by the bench's scenarios. This covers the readback of field positions, a read and an event colliding in the same cycle, the interrupt tracking a random mix of masks and events, and the soft reset pulse width.

// File: rtl/flashctl_pkg.sv
package flashctl_pkg;

  typedef enum logic [2:0] {
    A_CMD  = 3'd0,
    A_CFG  = 3'd1,
    A_TIM  = 3'd2,
    A_MASK = 3'd3,
    A_PEND = 3'd4,
    A_KEY  = 3'd5,
    A_LIVE = 3'd6,
    A_CEM  = 3'd7
  } reg_addr_e;

  localparam int LIVE_W = 7;
  localparam logic [7:0] CMD_SOFT_RESET = 8'hFF;

  function automatic logic [LIVE_W-1:0] pack_live(
    input logic nand_rdy, input logic ctl_rdy, input logic ecc_rdy,
    input logic err_seen, input logic [1:0] fix_cnt, input logic uncorr);
    pack_live = {uncorr, fix_cnt, err_seen, ecc_rdy, ctl_rdy, nand_rdy};
  endfunction

  function automatic logic both_ready(input logic [LIVE_W-1:0] live);
    both_ready = live[0] & live[1];
  endfunction

  function automatic logic is_reset_cmd(input logic [7:0] code);
    is_reset_cmd = (code == CMD_SOFT_RESET);
  endfunction

endpackage

// File: rtl/flashctl_keyguard.sv
module flashctl_keyguard #(
  parameter int          KEY_W   = 16,
  parameter logic [15:0] KEY_VAL = 16'hA25E
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_data,
  input  logic             prot_wr,
  input  logic             relock,
  output logic             unlocked,
  output logic             prot_commit
);

  logic key_match;
  logic open_q;

  assign key_match   = (key_data == KEY_VAL[KEY_W-1:0]);
  assign prot_commit = prot_wr & open_q;
  assign unlocked    = open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       open_q <= 1'b0;
    else if (relock)  open_q <= 1'b0;
    else if (key_wr)  open_q <= key_match;
    else if (prot_wr) open_q <= 1'b0;
  end

  // R2: the guarded write consumes the unlock
  assert_relock_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    prot_wr |=> !unlocked);

  // R2: the right key always opens
  assert_key_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_match && !relock) |=> unlocked);

  // R4: unrelated cycles keep the lock state
  assert_lock_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!key_wr && !prot_wr && !relock) |=> $stable(unlocked));

endmodule

// File: rtl/flashctl_irqcol.sv
module flashctl_irqcol #(
  parameter int N_EV = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_EV-1:0] ev,
  input  logic            rd_clr,
  input  logic            soft_clr,
  input  logic            mask_wr,
  input  logic [N_EV-1:0] mask_data,
  output logic [N_EV-1:0] pend,
  output logic [N_EV-1:0] mask,
  output logic            irq
);

  logic [N_EV-1:0] pend_q;
  logic [N_EV-1:0] mask_q;
  logic [N_EV-1:0] keep;
  logic [N_EV-1:0] gated;

  assign keep  = (rd_clr || soft_clr) ? '0 : pend_q;
  assign gated = pend_q & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= keep | ev;
      if (mask_wr) mask_q <= mask_data;
    end
  end

  assign pend = pend_q;
  assign mask = mask_q;
  assign irq  = |gated;

  // R8: an event is never dropped, even under a clearing read
  assert_event_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((pend & $past(ev)) == $past(ev)));

  // R8: a clearing read with no new event empties the register
  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && ev == '0) |=> (pend == '0));

  // R9: nothing unmasked may raise the interrupt
  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);

endmodule

// File: rtl/flashctl_regs.sv
module flashctl_regs
  import flashctl_pkg::*;
#(
  parameter int          ADDR_W  = 3,
  parameter int          DATA_W  = 32,
  parameter int          N_EV    = 6,
  parameter int          CFG_W   = 4,
  parameter int          TIM_W   = 26,
  parameter int          KEY_W   = 16,
  parameter logic [15:0] KEY_VAL = 16'hA25E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_EV-1:0]   ev_pulse,
  input  logic              st_nand_rdy,
  input  logic              st_ctl_rdy,
  input  logic              st_ecc_rdy,
  input  logic              st_err_seen,
  input  logic [1:0]        st_fix_cnt,
  input  logic              st_uncorr,
  output logic              irq,
  output logic [CFG_W-1:0]  if_cfg,
  output logic [TIM_W-1:0]  if_timing,
  output logic              ce_normal,
  output logic              dev_ready,
  output logic              soft_rst
);

  localparam int LIVE_PAD = DATA_W - LIVE_W;

  logic wr, rd;
  logic hit_cmd, hit_cfg, hit_tim, hit_mask, hit_pend, hit_key, hit_live, hit_cem;
  logic cmd_rst, prot_wr, prot_commit, unlocked;
  logic [CFG_W-1:0]  cfg_q;
  logic [TIM_W-1:0]  tim_q;
  logic              cem_q, soft_q;
  logic [N_EV-1:0]   pend, mask;
  logic [LIVE_W-1:0] live;

  assign wr = bus_sel & bus_we;
  assign rd = bus_sel & ~bus_we;

  assign hit_cmd  = (bus_addr == ADDR_W'(A_CMD));
  assign hit_cfg  = (bus_addr == ADDR_W'(A_CFG));
  assign hit_tim  = (bus_addr == ADDR_W'(A_TIM));
  assign hit_mask = (bus_addr == ADDR_W'(A_MASK));
  assign hit_pend = (bus_addr == ADDR_W'(A_PEND));
  assign hit_key  = (bus_addr == ADDR_W'(A_KEY));
  assign hit_live = (bus_addr == ADDR_W'(A_LIVE));
  assign hit_cem  = (bus_addr == ADDR_W'(A_CEM));

  assign cmd_rst = wr & hit_cmd & is_reset_cmd(bus_wdata[7:0]);
  assign prot_wr = wr & (hit_cfg | hit_tim);

  flashctl_keyguard #(.KEY_W(KEY_W), .KEY_VAL(KEY_VAL)) u_guard (
    .clk         (clk),
    .rst_n       (rst_n),
    .key_wr      (wr & hit_key),
    .key_data    (bus_wdata[KEY_W-1:0]),
    .prot_wr     (prot_wr),
    .relock      (cmd_rst),
    .unlocked    (unlocked),
    .prot_commit (prot_commit)
  );

  flashctl_irqcol #(.N_EV(N_EV)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        (ev_pulse),
    .rd_clr    (rd & hit_pend),
    .soft_clr  (cmd_rst),
    .mask_wr   (wr & hit_mask),
    .mask_data (bus_wdata[N_EV-1:0]),
    .pend      (pend),
    .mask      (mask),
    .irq       (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      tim_q  <= '0;
      cem_q  <= 1'b0;
      soft_q <= 1'b0;
    end else begin
      if (prot_commit && hit_cfg) cfg_q <= bus_wdata[CFG_W-1:0];
      if (prot_commit && hit_tim) tim_q <= bus_wdata[TIM_W-1:0];
      if (wr && hit_cem)          cem_q <= bus_wdata[0];
      soft_q <= cmd_rst;
    end
  end

  assign live      = pack_live(st_nand_rdy, st_ctl_rdy, st_ecc_rdy,
                               st_err_seen, st_fix_cnt, st_uncorr);
  assign dev_ready = both_ready(live);
  assign if_cfg    = cfg_q;
  assign if_timing = tim_q;
  assign ce_normal = cem_q;
  assign soft_rst  = soft_q;

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      unique case (1'b1)
        hit_cfg:  bus_rdata = DATA_W'(cfg_q);
        hit_tim:  bus_rdata = DATA_W'(tim_q);
        hit_mask: bus_rdata = DATA_W'(mask);
        hit_pend: bus_rdata = DATA_W'(pend);
        hit_key:  bus_rdata = DATA_W'(unlocked);
        hit_live: bus_rdata = {{LIVE_PAD{1'b0}}, live};
        hit_cem:  bus_rdata = DATA_W'(cem_q);
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R3: a locked guarded write leaves the configuration untouched
  assert_locked_cfg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_cfg && !unlocked) |=> $stable(if_cfg));

  assert_locked_tim_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_tim && !unlocked) |=> $stable(if_timing));

  // R11: the reset command always closes the lock and pulses soft_rst
  assert_cmd_relock_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rst |=> (!unlocked && soft_rst));

endmodule

// File: tb/sim_flashctl_regs.sv
`timescale 1ns/1ps
module sim_flashctl_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  ev_pulse = '0;
  logic        st_nand_rdy = 0, st_ctl_rdy = 0, st_ecc_rdy = 0, st_err_seen = 0, st_uncorr = 0;
  logic [1:0]  st_fix_cnt = '0;
  logic        irq, ce_normal, dev_ready, soft_rst;
  logic [3:0]  if_cfg;
  logic [25:0] if_timing;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  flashctl_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_pulse(ev_pulse),
    .st_nand_rdy(st_nand_rdy), .st_ctl_rdy(st_ctl_rdy), .st_ecc_rdy(st_ecc_rdy),
    .st_err_seen(st_err_seen), .st_fix_cnt(st_fix_cnt), .st_uncorr(st_uncorr),
    .irq(irq), .if_cfg(if_cfg), .if_timing(if_timing), .ce_normal(ce_normal),
    .dev_ready(dev_ready), .soft_rst(soft_rst));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd_ev(input logic [2:0] a, input logic [5:0] ev, output logic [31:0] v);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a; ev_pulse = ev;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_sel = 0; ev_pulse = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rd_ev(a, 6'd0, v);
  endtask

  task automatic pulse(input logic [5:0] ev);
    @(negedge clk);
    ev_pulse = ev;
    @(negedge clk);
    ev_pulse = '0;
  endtask

  // field packing restated from the R6 field list
  function automatic logic [31:0] timing_word(int ce, int busy, int ta, int rh, int rl, int wh, int wl);
    logic [31:0] t;
    t = 32'(wl % 16);
    t = t + 32'(wh % 16) * 16;
    t = t + 32'(rl % 16) * 256;
    t = t + 32'(rh % 16) * 4096;
    t = t + 32'(ta % 8) * 65536;
    t = t + 32'(busy % 32) * 524288;
    t = t + 32'(ce % 4) * 16777216;
    return t;
  endfunction

  // live status restated from R10
  function automatic logic [31:0] live_word(bit n, bit c, bit e, bit er, int cnt, bit u);
    int s;
    s = (n ? 1 : 0) + (c ? 2 : 0) + (e ? 4 : 0) + (er ? 8 : 0) + (cnt % 4) * 16 + (u ? 64 : 0);
    return 32'(s);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v, tw;
    logic [3:0]  m_cfg;
    logic [25:0] m_tim;
    logic [5:0]  m_mask, m_pend;
    bit          m_unl;
    void'($urandom(32'd20240611));

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 reset readback", v, 32'd0);
    end
    chk("R1 irq low", {31'd0, irq}, 32'd0);
    chk("R1 outputs zero", {if_cfg, if_timing, ce_normal, soft_rst}, 32'd0);

    // R3: locked writes ignored
    wr(3'd1, 32'hF);
    rd(3'd1, v); chk("R3 locked cfg", v, 32'd0);
    wr(3'd2, 32'h3FF_FFFF);
    rd(3'd2, v); chk("R3 locked timing", v, 32'd0);

    // R2/R4/R5: unlock survives unrelated write, one write only
    wr(3'd5, 32'h0000_A25E);
    rd(3'd5, v); chk("R2 lock opened", v, 32'd1);
    wr(3'd3, 32'h0);
    rd(3'd5, v); chk("R4 other write keeps unlock", v, 32'd1);
    wr(3'd1, 32'hFFF0_0006);
    rd(3'd1, v); chk("R5 cfg stored low bits", v, 32'd6);
    chk("R5 if_cfg pins", {28'd0, if_cfg}, 32'd6);
    rd(3'd5, v); chk("R2 relocked", v, 32'd0);
    wr(3'd1, 32'h1);
    rd(3'd1, v); chk("R3 second write ignored", v, 32'd6);

    // R6: timing fields
    tw = timing_word(2, 17, 5, 9, 3, 12, 7);
    wr(3'd5, 32'hA25E);
    wr(3'd2, tw);
    rd(3'd2, v); chk("R6 timing readback", v, tw);
    chk("R6 if_timing pins", {6'd0, if_timing}, tw);

    // R4: wrong key closes the lock
    wr(3'd5, 32'hA25E);
    wr(3'd5, 32'h1234);
    rd(3'd5, v); chk("R4 wrong key relocks", v, 32'd0);
    wr(3'd2, 32'h5);
    rd(3'd2, v); chk("R4 write after wrong key ignored", v, tw);

    // R12: chip-enable mode
    wr(3'd7, 32'h1);
    chk("R12 ce_normal set", {31'd0, ce_normal}, 32'd1);
    rd(3'd7, v); chk("R12 readback", v, 32'd1);

    // R7/R9: events and mask
    pulse(6'h20);
    chk("R9 masked off no irq", {31'd0, irq}, 32'd0);
    rd(3'd4, v); chk("R7 flash-ready bit", v, 32'h20);
    rd(3'd4, v); chk("R8 cleared by read", v, 32'h0);
    wr(3'd3, 32'h20);
    pulse(6'h20);
    chk("R9 irq raised", {31'd0, irq}, 32'd1);
    rd(3'd4, v);
    chk("R9 irq drops after clear", {31'd0, irq}, 32'd0);

    // R8: event colliding with clearing read
    pulse(6'h01);
    rd_ev(3'd4, 6'h08, v); chk("R8 read value before collision", v, 32'h01);
    rd(3'd4, v); chk("R8 collided event kept", v, 32'h08);

    // R10: live status patterns
    st_nand_rdy = 1; st_ctl_rdy = 0; st_ecc_rdy = 1; st_err_seen = 0; st_fix_cnt = 2; st_uncorr = 0;
    rd(3'd6, v); chk("R10 live pattern a", v, live_word(1, 0, 1, 0, 2, 0));
    chk("R10 not ready with one bit", {31'd0, dev_ready}, 32'd0);
    st_nand_rdy = 1; st_ctl_rdy = 1; st_ecc_rdy = 0; st_err_seen = 1; st_fix_cnt = 3; st_uncorr = 1;
    rd(3'd6, v); chk("R10 live pattern b", v, live_word(1, 1, 0, 1, 3, 1));
    chk("R10 ready with both", {31'd0, dev_ready}, 32'd1);
    st_nand_rdy = 0; st_ctl_rdy = 1; st_err_seen = 0; st_fix_cnt = 1; st_uncorr = 0;
    rd(3'd6, v); chk("R10 live pattern c", v, live_word(0, 1, 0, 0, 1, 0));
    chk("R10 not ready ctl only", {31'd0, dev_ready}, 32'd0);

    // R11: soft reset command
    wr(3'd5, 32'hA25E);
    pulse(6'h06);
    wr(3'd0, 32'hFF);
    chk("R11 soft_rst pulse", {31'd0, soft_rst}, 32'd1);
    @(negedge clk);
    chk("R11 soft_rst one cycle", {31'd0, soft_rst}, 32'd0);
    rd(3'd5, v); chk("R11 lock closed", v, 32'd0);
    rd(3'd4, v); chk("R11 pending cleared", v, 32'd0);
    wr(3'd5, 32'hA25E);
    wr(3'd0, 32'h70);
    chk("R11 other command no pulse", {31'd0, soft_rst}, 32'd0);
    rd(3'd5, v); chk("R11 other command keeps lock", v, 32'd1);
    wr(3'd5, 32'h0);

    // random phase against a bench model
    wr(3'd3, 32'h0);
    m_cfg = 4'h6; m_tim = tw[25:0]; m_unl = 0; m_mask = '0; m_pend = '0;
    for (int i = 0; i < 1500; i++) begin
      int op;
      logic [31:0] d;
      op = int'($urandom % 6);
      d  = $urandom;
      case (op)
        0: begin
          if (d[31]) d[15:0] = 16'hA25E;
          wr(3'd5, d);
          m_unl = (d[15:0] == 16'hA25E);
          rd(3'd5, v); chk("R2 random key state", v, {31'd0, m_unl});
        end
        1: begin
          wr(3'd1, d);
          if (m_unl) m_cfg = d[3:0];
          m_unl = 0;
          rd(3'd1, v); chk("R3 random cfg", v, {28'd0, m_cfg});
        end
        2: begin
          wr(3'd2, d);
          if (m_unl) m_tim = d[25:0];
          m_unl = 0;
          rd(3'd2, v); chk("R6 random timing", v, {6'd0, m_tim});
        end
        3: begin
          rd_ev(3'd4, d[5:0] & {6{d[8]}}, v);
          chk("R8 random pending read", v, {26'd0, m_pend});
          m_pend = d[5:0] & {6{d[8]}};
        end
        4: begin
          pulse(d[5:0]);
          m_pend = m_pend | d[5:0];
          chk("R7 random pending irq", {31'd0, irq}, {31'd0, |(m_pend & m_mask)});
        end
        default: begin
          wr(3'd3, d);
          m_mask = d[5:0];
          rd(3'd3, v); chk("R9 random mask", v, {26'd0, m_mask});
        end
      endcase
      chk("R9 random irq", {31'd0, irq}, {31'd0, |(m_pend & m_mask)});
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule